// File: doc/BRIEF.md
# Relative Branch and Bit-Set Execute Stage

This block is the execute stage of a small 8-bit microcontroller core. It takes 16-bit instruction words, one per instruction cycle, and carries out two of them. One is an unconditional branch relative to the program counter. The other sets a single bit in a data-memory register. Every other opcode retires as a no-operation that only advances the program counter. No status flag is touched.

Each instruction cycle is four clock cycles long, called quarter phases: decode, read, process and write. A bit-set fits in one instruction cycle. It reads the register in the read phase, ORs in the chosen bit in the process phase and writes it back in the write phase. A taken branch writes the new program counter in the write phase of its first cycle. It then spends a whole second instruction cycle idle, with a flush flag raised so that the fetch side can discard the word it prefetched.

The register address of a bit-set comes from a bank mode bit in the word. That bit picks one of three sources: a banked address built from the bank select input, a fixed access bank, or an indexed window based on an index register input.

Top module: `rbx_exec`

## Requirements
- R1: While reset is held low, `pc_o` is 0, `phase_o` is 0, `flush_o` is 0 and `dm_we_o` is 0.
- R2: `phase_o` steps 0, 1, 2, 3 and then back to 0 on every clock. An instruction word is taken from `instr_i` on the clock edge that ends phase 0, if `instr_valid_i` is high at that edge.
- R3: A word whose bits [15:11] are 11010 is a branch. Bits [10:0] hold a signed offset n from -1024 to 1023. At the edge that ends phase 3, `pc_o` becomes (word address + 2 + 2n) modulo 2^21.
- R4: After a branch, one whole instruction cycle is idle. During all four of its phases `flush_o` is 1, `pc_o` holds the branch target and `dm_we_o` is 0. A valid word offered in that cycle is ignored.
- R5: A word whose bits [15:12] are 1000 is a bit-set. Bits [11:9] give the bit index b, bit 8 is the mode bit a, and bits [7:0] give f. The register is read in phase 1. In phase 3 the value read OR (1<<b) is written back, so every other bit is left as it was.
- R6: When a is 1, the register address is {`bank_sel_i`, f}, whatever the state of `ext_mode_i`.
- R7: When a is 0 and `ext_mode_i` is 0, f values 0x00 to 0x5F address 0x000 to 0x05F, and f values 0x60 to 0xFF address 0xF60 to 0xFFF.
- R8: When a is 0 and `ext_mode_i` is 1, an f of 0x5F or less addresses `index_i` + f. A larger f uses the upper access-bank mapping of R7.
- R9: A valid word that is neither a branch nor a bit-set advances `pc_o` by 2 at the end of phase 0 and writes nothing.
- R10: If no valid word is offered in phase 0, `pc_o` does not change and nothing is written in that instruction cycle.
- R11: `dm_we_o` is 1 only in phase 3 of a bit-set. In that phase `dm_addr_o` holds the same address it had in phases 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one quarter phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is valid (sampled in phase 0) |
| pc_o | output | 21 | Program counter |
| phase_o | output | 2 | Current quarter phase, 0 to 3 |
| flush_o | output | 1 | High during the idle cycle after a branch |
| dm_addr_o | output | 12 | Data memory address |
| dm_rdata_i | input | 8 | Data memory read data |
| dm_wdata_o | output | 8 | Data memory write data |
| dm_we_o | output | 1 | Data memory write enable |
| bank_sel_i | input | 4 | Bank select register value |
| ext_mode_i | input | 1 | Enables indexed addressing for low f values |
| index_i | input | 8 | Index register value for indexed addressing |

## Verification
The bench drives branches at the two ends of the offset range starting from address 0, so the target wraps below zero and later above 2^21. A design with a bad sign extension or no modulo would show a wrong target in the very next cycle. Bit-set addresses are tried on both sides of the 0x5F split, with extended mode on and off and with banked mode on and off. A wrong comparison edge (less than versus less-or-equal) or a mode bit read the wrong way would put a bad address on the bus during phases 1 to 3. Bit-sets also hit an already-set bit and bit 0, and a wrong mask would show as extra or missing bits in the written byte. The bench offers a valid bit-set during the idle branch cycle. A design that fails to stall would write memory or move the counter there. Look-alike opcodes with one bit changed and invalid-word cycles check that only the right decodes do anything.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_BRA  = 2'd1,
        OPK_BSF  = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        QP_DECODE  = 2'd0,
        QP_READ    = 2'd1,
        QP_PROCESS = 2'd2,
        QP_WRITE   = 2'd3
    } qphase_e;

    localparam logic [4:0] BRA_CODE = 5'b11010;
    localparam logic [3:0] BSF_CODE = 4'b1000;

endpackage

// File: rtl/rbx_decode.sv
module rbx_decode
    import rbx_pkg::*;
(
    input  logic [4:0] opc_i,
    output op_kind_e   kind_o
);
    always_comb begin
        if (opc_i == BRA_CODE)
            kind_o = OPK_BRA;
        else if (opc_i[4:1] == BSF_CODE)
            kind_o = OPK_BSF;
        else
            kind_o = OPK_NONE;
    end
endmodule

// File: rtl/rbx_agen.sv
module rbx_agen #(
    parameter int              F_W    = 8,
    parameter int              BANK_W = 4,
    parameter logic [F_W-1:0]  SPLIT  = 8'h5F,
    localparam int             ADDR_W = BANK_W + F_W
) (
    input  logic              bank_mode_i,
    input  logic [F_W-1:0]    reg_f_i,
    input  logic [BANK_W-1:0] bank_sel_i,
    input  logic              ext_mode_i,
    input  logic [F_W-1:0]    index_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic low_half;
    assign low_half = (reg_f_i <= SPLIT);

    always_comb begin
        if (bank_mode_i)
            addr_o = {bank_sel_i, reg_f_i};
        else if (ext_mode_i && low_half)
            addr_o = ADDR_W'(index_i) + ADDR_W'(reg_f_i);
        else if (low_half)
            addr_o = {{BANK_W{1'b0}}, reg_f_i};
        else
            addr_o = {{BANK_W{1'b1}}, reg_f_i};
    end
endmodule

// File: rtl/rbx_bitset.sv
module rbx_bitset #(
    parameter int  DATA_W = 8,
    localparam int BIT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din_i,
    input  logic [BIT_W-1:0]  idx_i,
    output logic [DATA_W-1:0] dout_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout_o[i] = din_i[i] | (idx_i == BIT_W'(i));
    end
endmodule

// File: rtl/rbx_exec.sv
module rbx_exec
    import rbx_pkg::*;
#(
    parameter int  PC_W   = 21,
    parameter int  IW     = 16,
    parameter int  OFF_W  = 11,
    parameter int  DATA_W = 8,
    parameter int  F_W    = 8,
    parameter int  BANK_W = 4,
    localparam int ADDR_W = BANK_W + F_W,
    localparam int BIT_W  = $clog2(DATA_W),
    localparam int FLD_W  = BIT_W + 1 + F_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     instr_i,
    input  logic              instr_valid_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [1:0]        phase_o,
    output logic              flush_o,
    output logic [ADDR_W-1:0] dm_addr_o,
    input  logic [DATA_W-1:0] dm_rdata_i,
    output logic [DATA_W-1:0] dm_wdata_o,
    output logic              dm_we_o,
    input  logic [BANK_W-1:0] bank_sel_i,
    input  logic              ext_mode_i,
    input  logic [F_W-1:0]    index_i
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(2);

    typedef struct packed {
        qphase_e           phase;
        logic [PC_W-1:0]   pc;
        logic [FLD_W-1:0]  ir;
        op_kind_e          kind;
        logic              idle;
        logic [DATA_W-1:0] rd;
        logic [PC_W-1:0]   tgt;
    } exec_st_t;

    exec_st_t st_d, st_q;

    // decode of the incoming word
    op_kind_e word_kind;
    rbx_decode u_dec (
        .opc_i  (instr_i[IW-1 -: 5]),
        .kind_o (word_kind)
    );

    // fields of the held word
    logic [BIT_W-1:0]  bit_idx;
    logic              bank_mode;
    logic [F_W-1:0]    reg_f;
    logic [PC_W-1:0]   off_x2;
    assign bit_idx   = st_q.ir[FLD_W-1 -: BIT_W];
    assign bank_mode = st_q.ir[F_W];
    assign reg_f     = st_q.ir[F_W-1:0];
    assign off_x2    = {{(PC_W-OFF_W-1){st_q.ir[OFF_W-1]}}, st_q.ir[OFF_W-1:0], 1'b0};

    logic [ADDR_W-1:0] eff_addr;
    rbx_agen #(.F_W(F_W), .BANK_W(BANK_W)) u_agen (
        .bank_mode_i (bank_mode),
        .reg_f_i     (reg_f),
        .bank_sel_i  (bank_sel_i),
        .ext_mode_i  (ext_mode_i),
        .index_i     (index_i),
        .addr_o      (eff_addr)
    );

    logic [DATA_W-1:0] set_val;
    rbx_bitset #(.DATA_W(DATA_W)) u_set (
        .din_i  (st_q.rd),
        .idx_i  (bit_idx),
        .dout_o (set_val)
    );

    always_comb begin
        st_d       = st_q;
        st_d.phase = qphase_e'(st_q.phase + 2'd1);
        unique case (st_q.phase)
            QP_DECODE: begin
                if (st_q.idle) begin
                    st_d.kind = OPK_NONE;
                end else if (instr_valid_i) begin
                    st_d.ir   = instr_i[FLD_W-1:0];
                    st_d.kind = word_kind;
                    st_d.pc   = st_q.pc + PC_STEP;
                end else begin
                    st_d.kind = OPK_NONE;
                end
            end
            QP_READ: begin
                if (st_q.kind == OPK_BSF)
                    st_d.rd = dm_rdata_i;
                else if (st_q.kind == OPK_BRA)
                    st_d.tgt = off_x2;
            end
            QP_PROCESS: begin
                if (st_q.kind == OPK_BSF)
                    st_d.rd = set_val;
                else if (st_q.kind == OPK_BRA)
                    st_d.tgt = st_q.pc + st_q.tgt;
            end
            QP_WRITE: begin
                if (st_q.kind == OPK_BRA) begin
                    st_d.pc   = st_q.tgt;
                    st_d.idle = 1'b1;
                end else begin
                    st_d.idle = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: QP_DECODE, pc: '0, ir: '0, kind: OPK_NONE,
                      idle: 1'b0, rd: '0, tgt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    logic bsf_live;
    assign bsf_live   = (st_q.kind == OPK_BSF) && (st_q.phase != QP_DECODE);
    assign pc_o       = st_q.pc;
    assign phase_o    = st_q.phase;
    assign flush_o    = st_q.idle;
    assign dm_addr_o  = bsf_live ? eff_addr : '0;
    assign dm_we_o    = (st_q.kind == OPK_BSF) && (st_q.phase == QP_WRITE);
    assign dm_wdata_o = dm_we_o ? st_q.rd : '0;

    // ---------------- assertions ----------------
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3) |=> (phase_o == 2'd0));

    assert_flush_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && phase_o != 2'd3) |=> $stable(pc_o));

    assert_flush_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !dm_we_o);

    assert_one_bit_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> ($countones(dm_wdata_o ^ $past(dm_rdata_i, 2)) <= 1));

    assert_we_write_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> (phase_o == 2'd3));

    assert_addr_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> $stable(dm_addr_o));

endmodule

// File: tb/sim_rbx_exec.sv
module sim_rbx_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic        vld = 1'b0;
    logic [20:0] pc_o;
    logic [1:0]  phase_o;
    logic        flush_o;
    logic [11:0] dm_addr;
    logic [7:0]  dm_rdata;
    logic [7:0]  dm_wdata;
    logic        dm_we;
    logic [3:0]  bank = 4'h0;
    logic        ext = 1'b0;
    logic [7:0]  idx = 8'h00;

    int total = 0;
    int bad = 0;
    int exp_pc = 0;
    localparam int PCM = 32'h1FFFFF;

    logic [7:0] mem     [4096];
    logic [7:0] ref_mem [4096];

    always #2.5 clk = ~clk;

    rbx_exec u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_valid_i(vld),
        .pc_o(pc_o), .phase_o(phase_o), .flush_o(flush_o),
        .dm_addr_o(dm_addr), .dm_rdata_i(dm_rdata), .dm_wdata_o(dm_wdata),
        .dm_we_o(dm_we), .bank_sel_i(bank), .ext_mode_i(ext), .index_i(idx)
    );

    assign dm_rdata = mem[dm_addr];
    always @(posedge clk) if (dm_we) mem[dm_addr] <= dm_wdata;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int calc_ea(input logic a, input logic [7:0] f);
        if (a) return int'(bank) * 256 + int'(f);
        if (ext && f <= 8'h5F) return (int'(idx) + int'(f)) & 'hFFF;
        if (f <= 8'h5F) return int'(f);
        return 'hF00 + int'(f);
    endfunction

    // caller is just after a negedge with phase 0
    task automatic exec(input logic [15:0] w, input logic v);
        int kind, ea, b, pc0, nval, n, tgt;
        string areq, preq;
        kind = 0;
        if (v && w[15:11] == 5'b11010) kind = 1;
        else if (v && w[15:12] == 4'b1000) kind = 2;
        b    = int'(w[11:9]);
        ea   = calc_ea(w[8], w[7:0]);
        areq = w[8] ? "R6" : (ext ? "R8" : "R7");
        preq = v ? "R9" : "R10";
        pc0  = exp_pc;
        instr = w;
        vld   = v;
        chk("R2", "phase", 32'(phase_o), 0);
        chk(preq, "pc@q0", 32'(pc_o), pc0);
        chk("R11", "we@q0", 32'(dm_we), 0);
        chk("R4", "flush@q0", 32'(flush_o), 0);
        if (v) exp_pc = (pc0 + 2) & PCM;
        @(negedge clk);
        vld = 1'b0;
        for (int ph = 1; ph < 4; ph++) begin
            chk("R2", "phase", 32'(phase_o), ph);
            chk(preq, "pc", 32'(pc_o), exp_pc);
            if (kind == 2) chk(areq, "addr", 32'(dm_addr), ea);
            if (ph == 3 && kind == 2) begin
                nval = int'(ref_mem[ea]) | (1 << b);
                chk("R5", "wdata", 32'(dm_wdata), nval);
                chk("R11", "we@q3", 32'(dm_we), 1);
                ref_mem[ea] = 8'(nval);
            end else begin
                chk("R11", "we", 32'(dm_we), 0);
            end
            @(negedge clk);
        end
        if (kind == 2) chk("R5", "stored", 32'(mem[ea]), 32'(ref_mem[ea]));
        if (kind == 1) begin
            n   = w[10] ? int'(w[10:0]) - 2048 : int'(w[10:0]);
            tgt = (pc0 + 2 + 2 * n) & PCM;
            exp_pc = tgt;
            chk("R3", "target", 32'(pc_o), tgt);
            instr = 16'h8F21;   // valid bit-set offered during the idle cycle
            vld   = 1'b1;
            for (int ph = 0; ph < 4; ph++) begin
                chk("R2", "phase", 32'(phase_o), ph);
                chk("R4", "flush", 32'(flush_o), 1);
                chk("R4", "pc hold", 32'(pc_o), tgt);
                chk("R4", "no write", 32'(dm_we), 0);
                @(negedge clk);
            end
            vld = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i]     = 8'((i * 37 + 5) & 'hFE);
            ref_mem[i] = 8'((i * 37 + 5) & 'hFE);
        end
        repeat (3) @(negedge clk);
        chk("R1", "pc", 32'(pc_o), 0);
        chk("R1", "phase", 32'(phase_o), 0);
        chk("R1", "flush", 32'(flush_o), 0);
        chk("R1", "we", 32'(dm_we), 0);
        rst_n = 1'b1;

        exec(16'hD400, 1'b1);   // R3: n=-1024 from 0, wraps low
        exec(16'hD3FF, 1'b1);   // R3: n=1023, wraps high
        exec(16'h0000, 1'b1);   // R9
        exec(16'hFFFF, 1'b1);   // R9
        exec(16'hD805, 1'b1);   // R9: look-alike of branch
        exec(16'h9F00, 1'b1);   // R9: look-alike of bit-set
        exec(16'h8F22, 1'b0);   // R10: not valid
        exec(16'hD005, 1'b1);   // R3: n=5
        exec(16'hD7FF, 1'b1);   // R3: n=-1

        bank = 4'h3; ext = 1'b0; idx = 8'hF0;
        exec(16'h8F22, 1'b1);   // R6: bit7, bank 3
        exec(16'h8010, 1'b1);   // R7: bit0, low access
        exec(16'h8680, 1'b1);   // R7: bit3, upper access
        exec(16'h805F, 1'b1);   // R7: split edge
        ext = 1'b1;
        exec(16'h8A5F, 1'b1);   // R8: indexed, edge value
        exec(16'h8260, 1'b1);   // R8: above split
        exec(16'h8260, 1'b1);   // R5: bit already set
        exec(16'h8F22, 1'b1);   // R6: banked with ext on
        exec(16'h8A00, 1'b1);   // R8: indexed f=0
        exec(16'h0000, 1'b1);   // R9

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule